// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block regulates the current of one bridge with fixed off-time chopping. A synchronous flag from the sense comparator reports that the bridge current is above its reference. When the chopper accepts that flag, it raises `chop` so that the bridge sequencer turns the low-side switch off and lets the load current recirculate. `chop` stays high for a programmed one-shot interval and then for a fixed dead interval. After that the on phase starts again. A design instantiates the block once per bridge, and each instance has its own flag and its own off-time setting, so the channels run independently.

Every time is a count of clock cycles. For a set period after the on phase starts, the flag is masked so that the current spike from diode recovery cannot cut the on phase short. The on phase also has a minimum length. A trip that arrives after the mask ends but before that minimum is held and takes effect when the minimum is reached. The off-time setting is sampled once, at the moment an off phase starts.

Top module: `cot_chopper`

## Requirements
- R1: While `rst_n` is low and after its release, `chop` is low, and it stays low until a trip is accepted.
- R2: `trip_raw` passes through a two-flop synchronizer. In an on phase already longer than `MIN_ON` cycles, `chop` goes high on the third rising clock edge after `trip_raw` goes high.
- R3: For the first `BLANK` cycles of every on phase, the trip flag is ignored and is not remembered. A pulse that falls entirely inside this window leaves `chop` low.
- R4: An on phase lasts at least `MIN_ON` cycles. A trip seen after the blanking window and before `MIN_ON` is held, and `chop` then rises so that the on phase is exactly `MIN_ON` cycles. With the flag held high, every on phase is exactly `MIN_ON` cycles.
- R5: Each off phase keeps `chop` high for exactly `max(toff_cfg, TOFF_MIN) + DEAD` consecutive cycles. This is the one-shot time followed by the dead time.
- R6: A `toff_cfg` value below `TOFF_MIN`, zero included, gives a one-shot of `TOFF_MIN` cycles.
- R7: `toff_cfg` is sampled only on the edge that starts an off phase. A change during an off phase takes effect at the next off phase.
- R8: When `en` is low, `chop` is low from the next clock edge on, whatever the trip flag does. When `en` returns high, a new on phase starts with blanking armed and lasts at least `MIN_ON` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; low forces the on phase and clears all timers |
| trip_raw | input | 1 | Unsynchronized flag: sensed current above the reference |
| toff_cfg | input | TOFF_W | One-shot off time in cycles; sampled at the start of each off phase |
| chop | output | 1 | High during the off phase, one-shot plus dead time |

## Verification
On every cycle the assertions check three things: no on phase shorter than `MIN_ON`, no off phase shorter than `TOFF_MIN + DEAD`, and that `chop` falls after `en` drops and never rises from a disabled cycle. The exact length of each off phase for a given setting, the clamp of small settings, and the rule that a setting is sampled only when an off phase starts can only be shown by the bench's scenarios. The same holds for the difference between a pulse masked by blanking and a pulse held until the minimum on time, and for the three-edge synchronizer latency.

// File: rtl/cot_pkg.sv
package cot_pkg;
  typedef enum logic [1:0] {
    PH_ON   = 2'd0,
    PH_OFF  = 2'd1,
    PH_DEAD = 2'd2
  } phase_e;
endpackage

// File: rtl/cot_sync.sv
module cot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/cot_on_guard.sv
// On-phase guard: blanking mask, pending trip, minimum on time.
module cot_on_guard #(
  parameter int BLANK  = 4,
  parameter int MIN_ON = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trip,
  output logic fire
);
  localparam int CW   = $clog2(MIN_ON + 1);
  localparam int LAST = MIN_ON - 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          unmasked, at_min;

  always_comb begin
    unmasked = (cnt_q >= CW'(BLANK));
    at_min   = (cnt_q == CW'(LAST));
    fire     = !clr && at_min && (pend_q || trip);
    cnt_d    = cnt_q;
    pend_d   = pend_q;
    if (clr) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else begin
      if (!at_min) cnt_d = cnt_q + 1'b1;
      if (unmasked && trip) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/cot_off_timer.sv
// One-shot then dead-time down counter.
module cot_off_timer #(
  parameter int TOFF_W   = 16,
  parameter int TOFF_MIN = 2,
  parameter int DEAD     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              load_dead,
  input  logic [TOFF_W-1:0] toff_cfg,
  output logic              expired
);
  localparam logic [TOFF_W-1:0] MIN_V  = TOFF_W'(TOFF_MIN);
  localparam logic [TOFF_W-1:0] DEAD_V = TOFF_W'(DEAD - 1);

  logic [TOFF_W-1:0] cnt_q, cnt_d;
  logic [TOFF_W-1:0] eff;

  always_comb begin
    eff   = (toff_cfg < MIN_V) ? MIN_V : toff_cfg;
    cnt_d = cnt_q;
    if (!en)                 cnt_d = '0;
    else if (start)          cnt_d = eff - 1'b1;
    else if (load_dead)      cnt_d = DEAD_V;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cot_chopper.sv
module cot_chopper
  import cot_pkg::*;
#(
  parameter int TOFF_W      = 16,
  parameter int TOFF_MIN    = 2,
  parameter int BLANK       = 4,
  parameter int MIN_ON      = 12,
  parameter int DEAD        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              trip_raw,
  input  logic [TOFF_W-1:0] toff_cfg,
  output logic              chop
);
  phase_e phase_q, phase_d;
  logic   trip_s, fire, expired, guard_clr, load_dead;

  cot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(trip_raw), .q(trip_s)
  );

  assign guard_clr = !en || (phase_q != PH_ON);

  cot_on_guard #(.BLANK(BLANK), .MIN_ON(MIN_ON)) u_guard (
    .clk(clk), .rst_n(rst_n), .clr(guard_clr), .trip(trip_s), .fire(fire)
  );

  assign load_dead = (phase_q == PH_OFF) && expired;

  cot_off_timer #(.TOFF_W(TOFF_W), .TOFF_MIN(TOFF_MIN), .DEAD(DEAD)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .start(fire), .load_dead(load_dead),
    .toff_cfg(toff_cfg), .expired(expired)
  );

  always_comb begin
    phase_d = phase_q;
    if (!en) phase_d = PH_ON;
    else begin
      unique case (phase_q)
        PH_ON:   if (fire)    phase_d = PH_OFF;
        PH_OFF:  if (expired) phase_d = PH_DEAD;
        PH_DEAD: if (expired) phase_d = PH_ON;
        default:              phase_d = PH_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_ON;
    else        phase_q <= phase_d;
  end

  assign chop = (phase_q != PH_ON);
endmodule

// File: rtl/cot_chopper_chk.sv
module cot_chopper_chk #(
  parameter int TOFF_MIN = 2,
  parameter int MIN_ON   = 12,
  parameter int DEAD     = 3
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic chop
);
  logic [31:0] hi_len, lo_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len <= '0;
      lo_len <= '0;
    end else begin
      hi_len <= (en && chop)  ? hi_len + 1 : '0;
      lo_len <= (en && !chop) ? lo_len + 1 : '0;
    end
  end

  // R8
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !chop);
  // R8
  a_r8_no_rise_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chop) |-> $past(en));
  // R4
  a_r4_min_on: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chop) |-> (lo_len >= 32'(MIN_ON)));
  // R5
  a_r5_min_off: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(chop)) |-> (hi_len >= 32'(TOFF_MIN + DEAD)));
endmodule

bind cot_chopper cot_chopper_chk #(
  .TOFF_MIN(TOFF_MIN), .MIN_ON(MIN_ON), .DEAD(DEAD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .chop(chop)
);

// File: tb/cot_chopper_tb.sv
`timescale 1ns/1ps
module cot_chopper_tb;
  localparam int TOFF_W = 16, TOFF_MIN = 2, BLANK = 4, MIN_ON = 12, DEAD = 3;
  localparam int NV = 6;
  localparam logic [TOFF_W-1:0] TBL [NV] = '{16'd5, 16'd20, 16'd1, 16'd0, 16'd40, 16'd7};

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, trip_raw = 1'b0;
  logic [TOFF_W-1:0] toff_cfg = 16'd9;
  logic chop;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  cot_chopper #(.TOFF_W(TOFF_W), .TOFF_MIN(TOFF_MIN), .BLANK(BLANK),
                .MIN_ON(MIN_ON), .DEAD(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .trip_raw(trip_raw),
    .toff_cfg(toff_cfg), .chop(chop));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [TOFF_W-1:0] v);
    return (int'(v) < TOFF_MIN) ? TOFF_MIN : int'(v);
  endfunction

  task automatic wait_val(input logic v);
    do @(negedge clk); while (chop !== v);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev, hi, lo, n;
    logic seen;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 chop in reset", chop, 0);
    rst_n = 1'b1;
    seen = 1'b0;
    repeat (20) begin @(negedge clk); if (chop) seen = 1'b1; end
    chk("R1 chop idle after reset", seen, 0);

    // R2 synchronizer latency
    trip_raw = 1'b1;
    @(negedge clk); chk("R2 edge1", chop, 0);
    @(negedge clk); chk("R2 edge2", chop, 0);
    @(negedge clk); chk("R2 edge3", chop, 1);

    // R5/R6/R7/R4 vector table, trip held high
    prev = eff(toff_cfg);
    for (int i = 0; i < NV; i++) begin
      toff_cfg = TBL[i];               // captured value stays prev (R7)
      hi = 1;
      while (1) begin @(negedge clk); if (!chop) break; hi++; end
      chk($sformatf("R5 R6 R7 off length vec%0d", i), hi, prev + DEAD);
      lo = 1;
      while (1) begin @(negedge clk); if (chop) break; lo++; end
      chk($sformatf("R4 on length vec%0d", i), lo, MIN_ON);
      prev = eff(TBL[i]);
    end

    // R8 disable in off phase
    @(negedge clk); en = 1'b0;
    @(negedge clk); chk("R8 chop low after disable", chop, 0);
    seen = 1'b0;
    repeat (10) begin @(negedge clk); if (chop) seen = 1'b1; end
    chk("R8 stays low while disabled", seen, 0);
    en = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!chop);
    chk("R8 on phase after enable", n, MIN_ON);

    // R3 blanking: pulse inside mask is dropped
    trip_raw = 1'b0;
    wait_val(1'b0);
    trip_raw = 1'b1;
    repeat (2) @(negedge clk);
    trip_raw = 1'b0;
    seen = 1'b0;
    repeat (40) begin @(negedge clk); if (chop) seen = 1'b1; end
    chk("R3 masked pulse ignored", seen, 0);

    // R2 single pulse, then R4 held trip
    trip_raw = 1'b1;
    @(negedge clk); trip_raw = 1'b0;
    @(negedge clk);
    @(negedge clk); chk("R2 short pulse trips", chop, 1);
    wait_val(1'b0);
    lo = 1;
    repeat (5) begin @(negedge clk); if (!chop) lo++; end
    trip_raw = 1'b1;
    @(negedge clk); trip_raw = 1'b0; if (!chop) lo++;
    while (1) begin @(negedge clk); if (chop) break; lo++; end
    chk("R4 pending trip fires at min on", lo, MIN_ON);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule